// File: doc/BRIEF.md
# Receive Cell Classifier and Data-FIFO Router

This block sits on the receive side of a cell interface and decides, one cell per clock, where each arriving cell goes. A cell is offered for a single cycle as a valid strobe together with an OAM flag and a two-bit entry-type code taken from a connection lookup. The block routes it to the constant-bit-rate (CBR) processing path, to a non-CBR data-cell FIFO, or to discard. Three control inputs select whether receive is enabled, whether OAM cells go to the data FIFO, and whether cells of undefined entry type go to the data FIFO.

The data FIFO is represented only by its write pointer, a write strobe and a read pointer supplied by the consumer. The block owns the write pointer, clears it while the FIFO enable is low, advances it on every stored cell and on a test strobe, and detects the full condition against the read pointer. Per-cell outcomes (cell stored, data FIFO overrun, CBR path overrun) are given as one-cycle event pulses for a status block elsewhere. The decision is registered in a small route state machine with states RS_IDLE, RS_CBR, RS_CBR_LOST, RS_DATA and RS_DISCARD. Each clock the next state is chosen from the cell offered in that cycle: RS_IDLE when no cell is offered or receive is disabled, RS_CBR or RS_CBR_LOST for a CBR cell depending on whether the CBR path is busy, RS_DATA for a cell routed to the enabled data FIFO, and RS_DISCARD otherwise. Each state lasts one cycle, and the outputs are decoded from it.

Top module: `rx_cell_router`

## Requirements
- R1: After reset, cbr_push, fifo_wr_stb and all three event outputs are 0 and fifo_wr_ptr is 0.
- R2: When cfg_rx_en is 0, an offered cell causes no push, no write and no event in the following cycle.
- R3: A non-OAM cell with entry type 2'b00 is discarded silently when cfg_unk_sel is 0. When cfg_unk_sel is 1 it is handled as a non-CBR data cell.
- R4: A cell with cell_oam set is discarded silently when cfg_oam_sel is 0 and handled as a non-CBR data cell when it is 1, whatever its entry type.
- R5: A non-OAM cell whose entry type is 2'b01, 2'b10 or 2'b11 (default decode) produces a one-cycle cbr_push in the cycle after it is offered, provided cbr_busy was 0 when it was offered.
- R6: A CBR cell offered while cbr_busy is 1 produces no cbr_push and instead a one-cycle ev_cbr_ovr pulse in the following cycle.
- R7: A data cell accepted into a non-full FIFO produces fifo_wr_stb and ev_cell_stored together for one cycle, in the cycle after it is offered. fifo_wr_ptr then advances by one at the next clock and wraps from 255 to 0.
- R8: The FIFO is full when fifo_wr_ptr + 1 (mod 256) equals fifo_rd_ptr. A data cell meeting a full FIFO produces ev_fifo_ovr and no write, and the pointer is unchanged.
- R9: While cfg_fifo_en is 0, fifo_wr_ptr is cleared to 0 at each clock, and data cells are discarded without a write or any event.
- R10: A one-cycle tst_ptr_inc pulse advances fifo_wr_ptr by one. If it coincides with a FIFO write, the pointer advances by two.
- R11: At most one of cbr_push, fifo_wr_stb, ev_fifo_ovr and ev_cbr_ovr is high in any cycle, and each event lasts exactly one cycle per cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cell_vld | input | 1 | A cell is offered this cycle |
| cell_oam | input | 1 | Offered cell is an OAM cell |
| cell_etype | input | 2 | Entry-type code from the lookup |
| cbr_busy | input | 1 | CBR path cannot take a cell this cycle |
| cfg_rx_en | input | 1 | Receive enable |
| cfg_oam_sel | input | 1 | 1: OAM cells to data FIFO, 0: discard |
| cfg_unk_sel | input | 1 | 1: undefined-type cells to data FIFO, 0: discard |
| cfg_fifo_en | input | 1 | Data FIFO enable, 0 clears the write pointer |
| tst_ptr_inc | input | 1 | Test strobe, advances the write pointer |
| fifo_rd_ptr | input | 8 | Consumer read pointer |
| cbr_push | output | 1 | Hand the cell to the CBR path |
| fifo_wr_stb | output | 1 | Write the cell at fifo_wr_ptr |
| fifo_wr_ptr | output | 8 | Data FIFO write pointer |
| ev_cell_stored | output | 1 | Event: data cell stored |
| ev_fifo_ovr | output | 1 | Event: data cell lost, FIFO full |
| ev_cbr_ovr | output | 1 | Event: CBR cell lost, path busy |

## Verification
Two functions can meet in one cycle: a data-cell write that advances the pointer, and a test increment strobe that advances it as well. The bench offers a data cell and raises tst_ptr_inc in the cycle the resulting write strobe is visible. It then expects the pointer to have moved by exactly two at the next clock. A second overlap puts a cell that meets a full FIFO against the pointer comparison. The bench fills the FIFO by aiming the read pointer, and expects an overrun pulse with the pointer left where it was.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

    typedef enum logic [2:0] {
        RS_IDLE     = 3'd0,
        RS_CBR      = 3'd1,
        RS_CBR_LOST = 3'd2,
        RS_DATA     = 3'd3,
        RS_DISCARD  = 3'd4
    } route_st_e;

    typedef enum logic [1:0] {
        CLS_NONE    = 2'd0,
        CLS_CBR     = 2'd1,
        CLS_DATA    = 2'd2,
        CLS_DISCARD = 2'd3
    } cell_cls_e;

endpackage

// File: rtl/rxr_classify.sv
module rxr_classify
    import rxr_pkg::*;
#(
    parameter int ET_W = 2,
    parameter logic [(1<<ET_W)-1:0] CBR_CODES = '1 << 1
) (
    input  logic            vld,
    input  logic            oam,
    input  logic [ET_W-1:0] etype,
    input  logic            rx_en,
    input  logic            oam_sel,
    input  logic            unk_sel,
    output cell_cls_e       cls
);
    localparam int N_CODES = 1 << ET_W;

    logic [N_CODES-1:0] code_hit;
    logic               is_cbr_code;

    for (genvar g = 0; g < N_CODES; g++) begin : g_code
        assign code_hit[g] = (etype == ET_W'(g)) && CBR_CODES[g] && (g != 0);
    end

    assign is_cbr_code = |code_hit;

    always_comb begin
        if (!vld || !rx_en) begin
            cls = CLS_NONE;
        end else if (oam) begin
            cls = oam_sel ? CLS_DATA : CLS_DISCARD;
        end else if (etype == '0) begin
            cls = unk_sel ? CLS_DATA : CLS_DISCARD;
        end else if (is_cbr_code) begin
            cls = CLS_CBR;
        end else begin
            cls = CLS_DISCARD;
        end
    end
endmodule

// File: rtl/rxr_route_fsm.sv
module rxr_route_fsm
    import rxr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  cell_cls_e cls,
    input  logic      cbr_busy,
    input  logic      fifo_en,
    input  logic      fifo_full,
    output logic      cbr_push,
    output logic      wr_stb,
    output logic      ev_stored,
    output logic      ev_fifo_ovr,
    output logic      ev_cbr_ovr
);
    route_st_e st_q, st_d;

    always_comb begin
        unique case (cls)
            CLS_NONE:    st_d = RS_IDLE;
            CLS_CBR:     st_d = cbr_busy ? RS_CBR_LOST : RS_CBR;
            CLS_DATA:    st_d = fifo_en ? RS_DATA : RS_DISCARD;
            CLS_DISCARD: st_d = RS_DISCARD;
            default:     st_d = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RS_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        cbr_push    = 1'b0;
        wr_stb      = 1'b0;
        ev_stored   = 1'b0;
        ev_fifo_ovr = 1'b0;
        ev_cbr_ovr  = 1'b0;
        unique case (st_q)
            RS_IDLE:     ;
            RS_CBR:      cbr_push = 1'b1;
            RS_CBR_LOST: ev_cbr_ovr = 1'b1;
            RS_DATA: begin
                if (fifo_full) begin
                    ev_fifo_ovr = 1'b1;
                end else begin
                    wr_stb    = 1'b1;
                    ev_stored = 1'b1;
                end
            end
            RS_DISCARD:  ;
            default:     ;
        endcase
    end
endmodule

// File: rtl/rxr_wptr.sv
module rxr_wptr #(
    parameter int PTR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic             wr_stb,
    input  logic             tst_inc,
    input  logic [PTR_W-1:0] rd_ptr,
    output logic [PTR_W-1:0] wr_ptr,
    output logic             full
);
    logic [PTR_W-1:0] step;

    assign step = PTR_W'(wr_stb) + PTR_W'(tst_inc);
    assign full = (wr_ptr + PTR_W'(1)) == rd_ptr;

    always_ff @(posedge clk) begin
        if (!rst_n || !fifo_en) wr_ptr <= '0;
        else                    wr_ptr <= wr_ptr + step;
    end
endmodule

// File: rtl/rx_cell_router.sv
module rx_cell_router
    import rxr_pkg::*;
#(
    parameter int PTR_W = 8,
    parameter int ET_W  = 2,
    parameter logic [(1<<ET_W)-1:0] CBR_CODES = '1 << 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cell_vld,
    input  logic             cell_oam,
    input  logic [ET_W-1:0]  cell_etype,
    input  logic             cbr_busy,
    input  logic             cfg_rx_en,
    input  logic             cfg_oam_sel,
    input  logic             cfg_unk_sel,
    input  logic             cfg_fifo_en,
    input  logic             tst_ptr_inc,
    input  logic [PTR_W-1:0] fifo_rd_ptr,
    output logic             cbr_push,
    output logic             fifo_wr_stb,
    output logic [PTR_W-1:0] fifo_wr_ptr,
    output logic             ev_cell_stored,
    output logic             ev_fifo_ovr,
    output logic             ev_cbr_ovr
);
    cell_cls_e cls;
    logic      full;

    rxr_classify #(.ET_W(ET_W), .CBR_CODES(CBR_CODES)) u_cls (
        .vld     (cell_vld),
        .oam     (cell_oam),
        .etype   (cell_etype),
        .rx_en   (cfg_rx_en),
        .oam_sel (cfg_oam_sel),
        .unk_sel (cfg_unk_sel),
        .cls     (cls)
    );

    rxr_route_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cls         (cls),
        .cbr_busy    (cbr_busy),
        .fifo_en     (cfg_fifo_en),
        .fifo_full   (full),
        .cbr_push    (cbr_push),
        .wr_stb      (fifo_wr_stb),
        .ev_stored   (ev_cell_stored),
        .ev_fifo_ovr (ev_fifo_ovr),
        .ev_cbr_ovr  (ev_cbr_ovr)
    );

    rxr_wptr #(.PTR_W(PTR_W)) u_wptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .fifo_en (cfg_fifo_en),
        .wr_stb  (fifo_wr_stb),
        .tst_inc (tst_ptr_inc),
        .rd_ptr  (fifo_rd_ptr),
        .wr_ptr  (fifo_wr_ptr),
        .full    (full)
    );
endmodule

// File: rtl/rx_cell_router_chk.sv
module rx_cell_router_chk #(
    parameter int PTR_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_rx_en,
    input logic             cfg_fifo_en,
    input logic             tst_ptr_inc,
    input logic             cbr_busy,
    input logic             cell_vld,
    input logic [PTR_W-1:0] fifo_rd_ptr,
    input logic             cbr_push,
    input logic             fifo_wr_stb,
    input logic [PTR_W-1:0] fifo_wr_ptr,
    input logic             ev_cell_stored,
    input logic             ev_fifo_ovr,
    input logic             ev_cbr_ovr
);
    a_r2_rx_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rx_en |=> !(cbr_push || fifo_wr_stb || ev_cell_stored || ev_fifo_ovr || ev_cbr_ovr));

    a_r6_lost_no_push: assert property (@(posedge clk) disable iff (!rst_n)
        ev_cbr_ovr |-> !cbr_push);

    a_r7_write_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_wr_stb && cfg_fifo_en && !tst_ptr_inc) |=> fifo_wr_ptr == $past(fifo_wr_ptr) + PTR_W'(1));

    a_r8_ovr_only_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        ev_fifo_ovr |-> (!fifo_wr_stb && (fifo_wr_ptr + PTR_W'(1)) == fifo_rd_ptr));

    a_r8_ovr_holds_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_fifo_ovr && cfg_fifo_en && !tst_ptr_inc) |=> $stable(fifo_wr_ptr));

    a_r9_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_fifo_en |=> fifo_wr_ptr == '0);

    a_r11_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cbr_push, fifo_wr_stb, ev_fifo_ovr, ev_cbr_ovr}));

    a_r11_stored_with_write: assert property (@(posedge clk) disable iff (!rst_n)
        ev_cell_stored |-> fifo_wr_stb);

    a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_cbr_ovr && !$past(cell_vld)) |-> 1'b0);
endmodule

bind rx_cell_router rx_cell_router_chk #(.PTR_W(PTR_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_rx_en      (cfg_rx_en),
    .cfg_fifo_en    (cfg_fifo_en),
    .tst_ptr_inc    (tst_ptr_inc),
    .cbr_busy       (cbr_busy),
    .cell_vld       (cell_vld),
    .fifo_rd_ptr    (fifo_rd_ptr),
    .cbr_push       (cbr_push),
    .fifo_wr_stb    (fifo_wr_stb),
    .fifo_wr_ptr    (fifo_wr_ptr),
    .ev_cell_stored (ev_cell_stored),
    .ev_fifo_ovr    (ev_fifo_ovr),
    .ev_cbr_ovr     (ev_cbr_ovr)
);

// File: tb/rx_cell_router_bench.sv
`timescale 1ns/1ps
module rx_cell_router_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       cell_vld, cell_oam, cbr_busy;
    logic [1:0] cell_etype;
    logic       cfg_rx_en, cfg_oam_sel, cfg_unk_sel, cfg_fifo_en, tst_ptr_inc;
    logic [7:0] fifo_rd_ptr;
    logic       cbr_push, fifo_wr_stb, ev_cell_stored, ev_fifo_ovr, ev_cbr_ovr;
    logic [7:0] fifo_wr_ptr;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    rx_cell_router u_rx_cell_router (
        .clk(clk), .rst_n(rst_n), .cell_vld(cell_vld), .cell_oam(cell_oam),
        .cell_etype(cell_etype), .cbr_busy(cbr_busy), .cfg_rx_en(cfg_rx_en),
        .cfg_oam_sel(cfg_oam_sel), .cfg_unk_sel(cfg_unk_sel), .cfg_fifo_en(cfg_fifo_en),
        .tst_ptr_inc(tst_ptr_inc), .fifo_rd_ptr(fifo_rd_ptr), .cbr_push(cbr_push),
        .fifo_wr_stb(fifo_wr_stb), .fifo_wr_ptr(fifo_wr_ptr), .ev_cell_stored(ev_cell_stored),
        .ev_fifo_ovr(ev_fifo_ovr), .ev_cbr_ovr(ev_cbr_ovr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // outputs packed as {cbr_push, fifo_wr_stb, ev_cell_stored, ev_fifo_ovr, ev_cbr_ovr}
    function automatic logic [4:0] outs();
        return {cbr_push, fifo_wr_stb, ev_cell_stored, ev_fifo_ovr, ev_cbr_ovr};
    endfunction

    // Offer one cell at a negedge; on return, the routed outputs are visible.
    task automatic offer(input logic oam, input logic [1:0] et, input logic busy);
        cell_vld = 1'b1; cell_oam = oam; cell_etype = et; cbr_busy = busy;
        @(negedge clk);
        cell_vld = 1'b0; cell_oam = 1'b0; cell_etype = 2'b00; cbr_busy = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 outputs", 32'(outs()), 32'd0);
        check("R1 pointer", 32'(fifo_wr_ptr), 32'd0);
    endtask

    task automatic t_rx_off();
        cfg_rx_en = 1'b0;
        offer(1'b0, 2'b01, 1'b0);
        check("R2 cbr cell ignored", 32'(outs()), 32'd0);
        offer(1'b1, 2'b00, 1'b0);
        check("R2 oam cell ignored", 32'(outs()), 32'd0);
        cfg_rx_en = 1'b1;
    endtask

    task automatic t_unknown();
        logic [7:0] p;
        cfg_unk_sel = 1'b0;
        p = fifo_wr_ptr;
        offer(1'b0, 2'b00, 1'b0);
        check("R3 unknown discarded", 32'(outs()), 32'd0);
        @(negedge clk);
        check("R3 pointer unchanged", 32'(fifo_wr_ptr), 32'(p));
        cfg_unk_sel = 1'b1;
        offer(1'b0, 2'b00, 1'b0);
        check("R3 unknown stored", 32'(outs()), 32'b01100);
        @(negedge clk);
        check("R3 pointer advanced", 32'(fifo_wr_ptr), 32'(p + 8'd1));
    endtask

    task automatic t_oam();
        logic [7:0] p;
        cfg_oam_sel = 1'b0;
        p = fifo_wr_ptr;
        offer(1'b1, 2'b01, 1'b0);
        check("R4 oam discarded over cbr type", 32'(outs()), 32'd0);
        cfg_oam_sel = 1'b1;
        offer(1'b1, 2'b10, 1'b0);
        check("R4 oam stored over cbr type", 32'(outs()), 32'b01100);
        @(negedge clk);
        check("R4 pointer", 32'(fifo_wr_ptr), 32'(p + 8'd1));
    endtask

    task automatic t_cbr();
        for (int c = 1; c < 4; c++) begin
            offer(1'b0, 2'(c), 1'b0);
            check("R5 cbr push", 32'(outs()), 32'b10000);
        end
        @(negedge clk);
        check("R11 push lasts one cycle", 32'(outs()), 32'd0);
        offer(1'b0, 2'b11, 1'b1);
        check("R6 cbr lost", 32'(outs()), 32'b00001);
        @(negedge clk);
        check("R6 event single cycle", 32'(outs()), 32'd0);
    endtask

    task automatic t_test_inc_and_collision();
        logic [7:0] p;
        p = fifo_wr_ptr;
        tst_ptr_inc = 1'b1;
        @(negedge clk);
        tst_ptr_inc = 1'b0;
        check("R10 test inc", 32'(fifo_wr_ptr), 32'(p + 8'd1));
        p = fifo_wr_ptr;
        offer(1'b1, 2'b00, 1'b0);
        tst_ptr_inc = 1'b1;
        check("R7 write strobe", 32'(outs()), 32'b01100);
        @(negedge clk);
        tst_ptr_inc = 1'b0;
        check("R10 write plus inc", 32'(fifo_wr_ptr), 32'(p + 8'd2));
    endtask

    task automatic t_full();
        logic [7:0] p;
        p = fifo_wr_ptr;
        fifo_rd_ptr = p + 8'd2;
        offer(1'b1, 2'b00, 1'b0);
        check("R7 stores before full", 32'(outs()), 32'b01100);
        offer(1'b1, 2'b00, 1'b0);
        check("R8 overrun when full", 32'(outs()), 32'b00010);
        @(negedge clk);
        check("R8 pointer held", 32'(fifo_wr_ptr), 32'(p + 8'd1));
        fifo_rd_ptr = 8'd0;
    endtask

    task automatic t_fifo_off();
        cfg_fifo_en = 1'b0;
        @(negedge clk);
        check("R9 pointer cleared", 32'(fifo_wr_ptr), 32'd0);
        offer(1'b1, 2'b00, 1'b0);
        check("R9 data cell silent", 32'(outs()), 32'd0);
        tst_ptr_inc = 1'b1;
        @(negedge clk);
        tst_ptr_inc = 1'b0;
        check("R9 pointer stays zero", 32'(fifo_wr_ptr), 32'd0);
        cfg_fifo_en = 1'b1;
    endtask

    task automatic t_wrap();
        fifo_rd_ptr = 8'd5;
        tst_ptr_inc = 1'b1;
        for (int i = 0; i < 255; i++) @(negedge clk);
        tst_ptr_inc = 1'b0;
        check("R10 pointer at top", 32'(fifo_wr_ptr), 32'd255);
        offer(1'b1, 2'b00, 1'b0);
        check("R7 write at top", 32'(outs()), 32'b01100);
        @(negedge clk);
        check("R7 wrap to zero", 32'(fifo_wr_ptr), 32'd0);
    endtask

    initial begin
        rst_n = 1'b0; cell_vld = 1'b0; cell_oam = 1'b0; cell_etype = 2'b00; cbr_busy = 1'b0;
        cfg_rx_en = 1'b1; cfg_oam_sel = 1'b0; cfg_unk_sel = 1'b0; cfg_fifo_en = 1'b1;
        tst_ptr_inc = 1'b0; fifo_rd_ptr = 8'd0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_rx_off();
        t_unknown();
        t_oam();
        t_cbr();
        t_test_inc_and_collision();
        t_full();
        t_fifo_off();
        t_wrap();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule